// File: doc/BRIEF.md
# Timer Capture/Compare Unit

This block sits beside a free-running 16-bit timer and holds one 16-bit capture/compare register. A 4-bit mode field chooses what the block does with that register. In the capture modes the block passes an external input pin through a two-flop synchroniser, detects the selected edge, and, after an optional edge prescaler (every edge, every 4th rising edge or every 16th rising edge), copies the timer value into the register and raises a sticky flag.

In the compare modes the register is matched against the timer input every clock. A match is taken once per timer value: a timer that stays on the matching value for several clocks yields a single event. Depending on the mode, the event drives the output pin high, drives it low, only raises the flag, or raises the flag and pulses a timer-clear strobe together with a conversion-start strobe that is gated by a converter-enable input. The timer itself and any bus decoding lie outside the block. Software writes the mode field, the register and a flag-clear strobe through simple write-enable ports.

Top module: `capcmp_unit`

## Requirements
- R1: Mode 4'b0000 disables the block: no capture and no match action occur, the output pin is driven low, and the edge prescaler counter is cleared.
- R2: Mode 4'b0100 captures on each falling edge and mode 4'b0101 on each rising edge of the input pin; an edge applied before clock edge N loads the register at clock edge N+2 (two synchroniser flops and one edge-history flop), and the opposite edge causes no capture.
- R3: Mode 4'b0110 captures on every 4th rising edge and mode 4'b0111 on every 16th rising edge, counting from the last mode write.
- R4: Each capture loads all 16 bits of the timer input into the register and sets the flag.
- R5: On a match, mode 4'b1000 drives the output pin high and mode 4'b1001 drives it low; the pin and the flag change at the clock edge where the timer first equals the register.
- R6: On a match, mode 4'b1010 sets the flag and leaves the output pin unchanged.
- R7: On a match, mode 4'b1011 sets the flag and drives timer_clr_o high for one cycle; conv_start_o pulses with it only when adc_on_i is high.
- R8: A match is acted on once per timer value: while the timer holds the matching value, no further flag set or strobe follows until the timer leaves and returns or the mode is rewritten.
- R9: Any write to the mode field clears the edge prescaler counter, so edges counted before the write do not contribute to the next capture.
- R10: The flag stays set until flag_clr_i is asserted; a capture or match in the same cycle as the clear wins; irq_o is the flag gated by irq_en_i.
- R11: A register write loads reg_wdata_i into the register and takes priority over a capture in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_we_i | input | 1 | Write strobe for the mode field |
| mode_i | input | 4 | New mode value |
| reg_we_i | input | 1 | Write strobe for the capture/compare register |
| reg_wdata_i | input | 16 | New register value |
| flag_clr_i | input | 1 | Clears the sticky flag |
| irq_en_i | input | 1 | Interrupt enable |
| adc_on_i | input | 1 | Converter enabled; gates the conversion strobe |
| timer_i | input | 16 | Free-running timer value |
| pin_i | input | 1 | Asynchronous capture input pin |
| reg_o | output | 16 | Capture/compare register contents |
| pin_o | output | 1 | Compare output pin |
| flag_o | output | 1 | Sticky event flag |
| irq_o | output | 1 | Interrupt request |
| timer_clr_o | output | 1 | One-cycle timer clear strobe |
| conv_start_o | output | 1 | One-cycle conversion-start strobe |

## Verification
A stale prescaler count shows at reg_o as a capture that comes one or more pin pulses too early or too late, visible within six clocks of the offending edge. A lost or stuck match-seen bit shows as a missing flag or as repeated timer_clr_o pulses in the very next cycle while the timer holds its value. A mode decode error shows at pin_o or at the strobes one clock after the match, and a wrong synchroniser depth shifts every capture by a cycle, which the latency check catches at the edge itself.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
  localparam logic [3:0] MODE_OFF      = 4'b0000;
  localparam logic [3:0] MODE_CAP_FALL = 4'b0100;
  localparam logic [3:0] MODE_CAP_RISE = 4'b0101;
  localparam logic [3:0] MODE_CMP_HI   = 4'b1000;
  localparam logic [3:0] MODE_CMP_LO   = 4'b1001;
  localparam logic [3:0] MODE_CMP_FLAG = 4'b1010;
  localparam logic [3:0] MODE_CMP_SPEC = 4'b1011;

  function automatic logic is_prescaled(logic [3:0] m);
    return m[3:1] == 3'b011;
  endfunction

  function automatic logic is_compare(logic [3:0] m);
    return m[3:2] == 2'b10;
  endfunction
endpackage

// File: rtl/capcmp_sync.sv
module capcmp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  // [STAGES-1:0] synchroniser, [STAGES] edge history
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign rise_o =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/capcmp_presc.sv
module capcmp_presc #(
  parameter int unsigned DIV_LO = 4,
  parameter int unsigned DIV_HI = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic sel_hi_i,
  input  logic rise_i,
  output logic fire_o
);
  localparam int unsigned CntW = (DIV_HI > 1) ? $clog2(DIV_HI) : 1;
  localparam logic [CntW-1:0] LastLo = CntW'(DIV_LO - 1);
  localparam logic [CntW-1:0] LastHi = CntW'(DIV_HI - 1);

  logic [CntW-1:0] cnt_q;
  logic            last;

  assign last   = cnt_q == (sel_hi_i ? LastHi : LastLo);
  assign fire_o = en_i & rise_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (en_i && rise_i)  cnt_q <= last ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/capcmp_match.sv
module capcmp_match #(
  parameter int unsigned TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          clr_i,
  input  logic [TW-1:0] timer_i,
  input  logic [TW-1:0] ref_i,
  output logic          hit_o
);
  logic eq, seen_q;

  assign eq    = timer_i == ref_i;
  assign hit_o = en_i & eq & ~seen_q;

  // remembers that the current equal state was already acted on
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    seen_q <= 1'b0;
    else if (clr_i) seen_q <= 1'b0;
    else            seen_q <= en_i & eq;
  end
endmodule

// File: rtl/capcmp_unit.sv
module capcmp_unit
  import capcmp_pkg::*;
#(
  parameter int unsigned TW        = 16,
  parameter int unsigned SYNC_STG  = 2,
  parameter int unsigned DIV_LO    = 4,
  parameter int unsigned DIV_HI    = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_we_i,
  input  logic [3:0]    mode_i,
  input  logic          reg_we_i,
  input  logic [TW-1:0] reg_wdata_i,
  input  logic          flag_clr_i,
  input  logic          irq_en_i,
  input  logic          adc_on_i,
  input  logic [TW-1:0] timer_i,
  input  logic          pin_i,
  output logic [TW-1:0] reg_o,
  output logic          pin_o,
  output logic          flag_o,
  output logic          irq_o,
  output logic          timer_clr_o,
  output logic          conv_start_o
);
  logic [3:0]    mode_q;
  logic [TW-1:0] reg_q;
  logic          flag_q, pin_q, tclr_q, conv_q;
  logic          rise, fall, presc_fire, hit, cap_fire, spec_hit;

  capcmp_sync #(.STAGES(SYNC_STG)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  capcmp_presc #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) i_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (mode_we_i | (mode_q == MODE_OFF)),
    .en_i     (is_prescaled(mode_q)),
    .sel_hi_i (mode_q[0]),
    .rise_i   (rise),
    .fire_o   (presc_fire)
  );

  capcmp_match #(.TW(TW)) i_match (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (is_compare(mode_q)),
    .clr_i   (mode_we_i),
    .timer_i (timer_i),
    .ref_i   (reg_q),
    .hit_o   (hit)
  );

  assign cap_fire = ((mode_q == MODE_CAP_FALL) & fall)
                  | ((mode_q == MODE_CAP_RISE) & rise)
                  | presc_fire;
  assign spec_hit = hit & (mode_q == MODE_CMP_SPEC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OFF;
      reg_q  <= '0;
      flag_q <= 1'b0;
      pin_q  <= 1'b0;
      tclr_q <= 1'b0;
      conv_q <= 1'b0;
    end else begin
      if (mode_we_i) mode_q <= mode_i;

      if (reg_we_i)      reg_q <= reg_wdata_i;
      else if (cap_fire) reg_q <= timer_i;

      if (cap_fire || hit) flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;

      if (mode_q == MODE_OFF)                  pin_q <= 1'b0;
      else if (hit && mode_q == MODE_CMP_HI)   pin_q <= 1'b1;
      else if (hit && mode_q == MODE_CMP_LO)   pin_q <= 1'b0;

      tclr_q <= spec_hit;
      conv_q <= spec_hit & adc_on_i;
    end
  end

  assign reg_o        = reg_q;
  assign pin_o        = pin_q;
  assign flag_o       = flag_q;
  assign irq_o        = flag_q & irq_en_i;
  assign timer_clr_o  = tclr_q;
  assign conv_start_o = conv_q;
endmodule

// File: rtl/capcmp_chk.sv
module capcmp_chk #(
  parameter int unsigned TW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mode_we_i,
  input logic          flag_clr_i,
  input logic [TW-1:0] timer_i,
  input logic [TW-1:0] reg_o,
  input logic          pin_o,
  input logic          flag_o,
  input logic          timer_clr_o,
  input logic          conv_start_o,
  input logic [3:0]    mode_q
);
  p_off_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 4'b0000) |=> (!pin_o && !timer_clr_o && !conv_start_o));

  p_pin_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 4'b1010) |=> $stable(pin_o));

  p_special_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timer_clr_o |-> flag_o);

  p_conv_with_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> timer_clr_o);

  p_single_event_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timer_clr_o && $stable(timer_i) && $stable(reg_o) && !$past(mode_we_i))
      |=> !timer_clr_o);

  p_flag_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !flag_clr_i) |=> flag_o);
endmodule

bind capcmp_unit capcmp_chk #(.TW(TW)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_we_i    (mode_we_i),
  .flag_clr_i   (flag_clr_i),
  .timer_i      (timer_i),
  .reg_o        (reg_o),
  .pin_o        (pin_o),
  .flag_o       (flag_o),
  .timer_clr_o  (timer_clr_o),
  .conv_start_o (conv_start_o),
  .mode_q       (mode_q)
);

// File: tb/test_capcmp_unit.sv
module test_capcmp_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_we_i = 1'b0;
  logic [3:0]  mode_i = 4'b0;
  logic        reg_we_i = 1'b0;
  logic [15:0] reg_wdata_i = '0;
  logic        flag_clr_i = 1'b0;
  logic        irq_en_i = 1'b0;
  logic        adc_on_i = 1'b0;
  logic [15:0] timer_i = '0;
  logic        pin_i = 1'b0;
  logic [15:0] reg_o;
  logic        pin_o, flag_o, irq_o, timer_clr_o, conv_start_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] exp_reg = '0;

  always #2.5 clk_i = ~clk_i;

  capcmp_unit i_capcmp_unit (
    .clk_i, .rst_ni, .mode_we_i, .mode_i, .reg_we_i, .reg_wdata_i,
    .flag_clr_i, .irq_en_i, .adc_on_i, .timer_i, .pin_i,
    .reg_o, .pin_o, .flag_o, .irq_o, .timer_clr_o, .conv_start_o
  );

  task automatic cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_mode(logic [3:0] m);
    mode_i = m; mode_we_i = 1'b1; cyc(1); mode_we_i = 1'b0;
  endtask

  task automatic wr_reg(logic [15:0] v);
    reg_wdata_i = v; reg_we_i = 1'b1; cyc(1); reg_we_i = 1'b0;
    exp_reg = v;
  endtask

  task automatic clr_flag();
    flag_clr_i = 1'b1; cyc(1); flag_clr_i = 1'b0;
  endtask

  task automatic pulse(logic [15:0] rt, logic [15:0] ft);
    timer_i = rt; pin_i = 1'b1; cyc(3);
    timer_i = ft; pin_i = 1'b0; cyc(3);
  endtask

  // rising edges per capture; 0 means falling-edge mode
  function automatic int div_of(logic [3:0] m);
    case (m)
      4'b0101: return 1;
      4'b0110: return 4;
      4'b0111: return 16;
      default: return 0;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired act=hung exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    check("R1 reset reg", reg_o, 0);
    check("R1 reset flag", flag_o, 0);
    check("R1 reset pin", pin_o, 0);
    check("R10 reset irq", irq_o, 0);
    check("R7 reset tclr", timer_clr_o, 0);

    // R2 rising capture, latency
    wr_mode(4'b0101);
    timer_i = 16'hA5C3; pin_i = 1'b1;
    cyc(2);
    check("R2 before latency", reg_o, exp_reg);
    cyc(1);
    exp_reg = 16'hA5C3;
    check("R2 rise capture", reg_o, exp_reg);
    check("R4 flag on capture", flag_o, 1);
    clr_flag();
    timer_i = 16'h1111; pin_i = 1'b0; cyc(4);
    check("R2 fall ignored in rise mode", reg_o, exp_reg);
    check("R2 no flag on fall", flag_o, 0);

    // R2 falling capture
    wr_mode(4'b0100);
    pulse(16'h2222, 16'hF00D);
    exp_reg = 16'hF00D;
    check("R2 fall capture", reg_o, exp_reg);

    // R11 write beats capture
    timer_i = 16'h3333; pin_i = 1'b1; cyc(3);
    timer_i = 16'h4444; pin_i = 1'b0; cyc(2);
    wr_reg(16'h5A5A);
    check("R11 write over capture", reg_o, 16'h5A5A);

    // R3 divide by 4 and 16
    wr_mode(4'b0110);
    for (int k = 1; k <= 3; k++) pulse(16'(k), 16'h0);
    check("R3 no capture before 4th", reg_o, exp_reg);
    pulse(16'h0404, 16'h0);
    exp_reg = 16'h0404;
    check("R3 capture on 4th", reg_o, exp_reg);
    wr_mode(4'b0111);
    for (int k = 1; k <= 15; k++) pulse(16'(k + 100), 16'h0);
    check("R3 no capture before 16th", reg_o, exp_reg);
    pulse(16'hBEEF, 16'h0);
    exp_reg = 16'hBEEF;
    check("R3 capture on 16th", reg_o, exp_reg);

    // R9 mode write clears prescaler
    wr_mode(4'b0110);
    pulse(16'h0A01, 16'h0); pulse(16'h0A02, 16'h0);
    wr_mode(4'b0110);
    pulse(16'h0A03, 16'h0); pulse(16'h0A04, 16'h0);
    check("R9 count restarted", reg_o, exp_reg);
    pulse(16'h0A05, 16'h0); pulse(16'h0A06, 16'h0);
    exp_reg = 16'h0A06;
    check("R9 capture after restart", reg_o, exp_reg);

    // random capture runs
    for (int it = 0; it < 12; it++) begin
      logic [3:0] m;
      int n, rises;
      logic any;
      m = 4'b0100 + 4'($urandom % 4);
      wr_mode(m);
      clr_flag();
      n = 1 + int'($urandom % 20);
      rises = 0; any = 1'b0;
      for (int k = 0; k < n; k++) begin
        logic [15:0] rt, ft;
        rt = 16'($urandom); ft = 16'($urandom);
        pulse(rt, ft);
        rises++;
        if (div_of(m) == 0) begin exp_reg = ft; any = 1'b1; end
        else if (rises % div_of(m) == 0) begin exp_reg = rt; any = 1'b1; end
      end
      check("R3 R4 random capture reg", reg_o, exp_reg);
      check("R4 random capture flag", flag_o, any);
    end

    // R5 compare high / low
    timer_i = 16'h0001;
    wr_mode(4'b1000);
    wr_reg(16'h1234);
    clr_flag();
    cyc(2);
    check("R5 no match pin", pin_o, 0);
    timer_i = 16'h1234; cyc(1);
    check("R5 match drives high", pin_o, 1);
    check("R5 match flag", flag_o, 1);
    clr_flag(); cyc(3);
    check("R8 held match no refire", flag_o, 0);
    timer_i = 16'h0; wr_mode(4'b1001);
    timer_i = 16'h1234; cyc(1);
    check("R5 match drives low", pin_o, 0);

    // R6 flag only
    timer_i = 16'h0; wr_mode(4'b1000);
    timer_i = 16'h1234; cyc(1);
    timer_i = 16'h0; wr_mode(4'b1010); clr_flag();
    timer_i = 16'h1234; cyc(1);
    check("R6 pin unchanged", pin_o, 1);
    check("R6 flag set", flag_o, 1);

    // R7 special event
    timer_i = 16'h0; wr_mode(4'b1011); clr_flag();
    adc_on_i = 1'b1; timer_i = 16'h1234; cyc(1);
    check("R7 timer clear", timer_clr_o, 1);
    check("R7 conv start", conv_start_o, 1);
    check("R7 flag", flag_o, 1);
    cyc(1);
    check("R8 single clear pulse", timer_clr_o, 0);
    adc_on_i = 1'b0; timer_i = 16'h0; cyc(1);
    timer_i = 16'h1234; cyc(1);
    check("R7 clear without adc", timer_clr_o, 1);
    check("R7 no conv when adc off", conv_start_o, 0);

    // R10 irq gating, set beats clear
    irq_en_i = 1'b0; cyc(1);
    check("R10 irq masked", irq_o, 0);
    irq_en_i = 1'b1; cyc(1);
    check("R10 irq enabled", irq_o, 1);
    clr_flag();
    check("R10 flag cleared", flag_o, 0);
    check("R10 irq follows", irq_o, 0);
    timer_i = 16'h0; cyc(1);
    timer_i = 16'h1234; flag_clr_i = 1'b1; cyc(1); flag_clr_i = 1'b0;
    check("R10 set wins over clear", flag_o, 1);

    // R1 disabled
    timer_i = 16'h0; wr_mode(4'b1000); timer_i = 16'h1234; cyc(1);
    wr_mode(4'b0000); cyc(1);
    check("R1 pin low when off", pin_o, 0);
    clr_flag();
    pulse(16'h7777, 16'h8888);
    timer_i = 16'h1234; cyc(2);
    check("R1 no capture when off", reg_o, exp_reg);
    check("R1 no flag when off", flag_o, 0);
    check("R1 no strobe when off", timer_clr_o, 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule